// File: doc/BRIEF.md
# Password-Gated Watchdog Reset Controller

This block is a memory-mapped watchdog that counts down at a slow, fixed rate and raises a reset request when the count runs out while a full reset is configured. It holds three registers behind a simple valid/write/address/data bus: a control register with a 2-bit reset configuration field, a status register that firmware uses to pass boot and partition information across a restart, and a 20-bit tick counter. Every register write must carry the key byte 0x5A in the top eight bits of the write data. A write without this key does nothing.

The tick comes from a divider. It divides an enable input, `tick_src`, by `TICK_DIV`. With `tick_src` tied high and the default divider, a system clock of about 100 MHz gives roughly 65536 ticks per second, so a loaded value of 65536 is about one second. Software arms the watchdog by writing the configuration value 2 and keeps it alive by reloading the count register. It stops the watchdog by writing a control word whose configuration field is not 2, for example 0x102.

Top module: `guarded_wdog_ctrl`

## Requirements
- R1: After reset, reads of control (offset 0x1C), status (0x20) and count (0x24) all return 0, and `reset_req` is low.
- R2: A write whose data bits 31:24 differ from 0x5A changes no register.
- R3: Reads always return 0 in bits 31:24. Control and status return bits 23:0 as last written. The count returns its live value in bits 19:0, and bits 23:20 read as 0.
- R4: The count moves only while the control bits 5:4 equal 2. The values 0, 1 and 3 in that field leave the count frozen and never produce a reset request.
- R5: While armed, the count drops by exactly one every `TICK_DIV` cycles in which `tick_src` is high. A write to the count restarts the divider, so the first decrement comes `TICK_DIV` enabled cycles after the write. With `tick_src` low, the count holds.
- R6: When the count is 0 and the configuration field is 2, `reset_req` goes high one cycle later for exactly one cycle. In that same cycle the configuration field reads 0 and the count holds at 0.
- R7: A keyed write to the count while armed reloads it at once and moves the expiry to a time measured from that write.
- R8: Writing 0x5A000102 to control disarms the watchdog: the count freezes, no request follows, and control reads 0x102.
- R9: The status register changes only on a keyed status write. Expiry and writes to the other registers leave it intact, including the halt pattern 0x555, which has bit 6 set.
- R10: A keyed count write loads only data bits 19:0. Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_src | input | 1 | Enable pulses that the divider turns into count ticks |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data, with the key in bits 31:24 |
| bus_rdata | output | DATA_W | Read data for the selected register, 0 when no read is selected |
| reset_req | output | 1 | One-cycle reset request on expiry |

## Verification
The bench sweeps load values from 0 to 5 with a divider of 3. On every cycle it compares the count and the request against a closed-form expiry time. An off-by-one in the divider restart or in the registered request would move the pulse, and a request held for two cycles would show up at once. Load value 0 is included because a design that tests only the 1-to-0 transition would never fire when armed at zero. Other tests use unkeyed writes, the three configuration values that do not arm, a held `tick_src`, a mid-count reload and a stop. These catch a design that ignores the key, counts in the wrong mode, or lets expiry clobber the status word.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int        KEY_W       = 8;
   localparam logic [7:0] KEY_VALUE  = 8'h5A;
   localparam int        OFS_CTRL    = 'h1C;
   localparam int        OFS_STAT    = 'h20;
   localparam int        OFS_COUNT   = 'h24;
   localparam int        CFG_LSB     = 4;
   localparam logic [1:0] CFG_FULL   = 2'd2;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_CTRL  = 2'd1,
      SEL_STAT  = 2'd2,
      SEL_COUNT = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/wdog_bus_gate.sv
module wdog_bus_gate
   import wdog_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [KEY_W-1:0]  key,
   output logic              wr_ctrl,
   output logic              wr_stat,
   output logic              wr_cnt,
   output reg_sel_e          rd_sel
);
   reg_sel_e hit;
   logic     key_ok;

   always_comb begin
      unique case (bus_addr)
         ADDR_W'(OFS_CTRL):  hit = SEL_CTRL;
         ADDR_W'(OFS_STAT):  hit = SEL_STAT;
         ADDR_W'(OFS_COUNT): hit = SEL_COUNT;
         default:            hit = SEL_NONE;
      endcase
   end

   assign key_ok  = (key == KEY_VALUE);
   assign wr_ctrl = bus_valid && bus_write && key_ok && (hit == SEL_CTRL);
   assign wr_stat = bus_valid && bus_write && key_ok && (hit == SEL_STAT);
   assign wr_cnt  = bus_valid && bus_write && key_ok && (hit == SEL_COUNT);
   assign rd_sel  = (bus_valid && !bus_write) ? hit : SEL_NONE;
endmodule

// File: rtl/wdog_tick_div.sv
module wdog_tick_div #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src,
   input  logic restart,
   output logic tick
);
   localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [DW-1:0] LAST = DW'(DIV - 1);

   logic [DW-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            phase_q <= '0;
      else if (restart)      phase_q <= '0;
      else if (src)          phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
   end

   assign tick = src && !restart && (phase_q == LAST);
endmodule

// File: rtl/wdog_down_cnt.sv
module wdog_down_cnt #(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic         zero
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (load)     cnt <= load_val;
      else if (dec)      cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/guarded_wdog_ctrl.sv
module guarded_wdog_ctrl
   import wdog_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 20,
   parameter int TICK_DIV = 1526
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_src,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              reset_req
);
   localparam int PAY_W = DATA_W - KEY_W;

   generate
      if (PAY_W < 12)      begin : g_bad_w   $error("payload too narrow for config field"); end
      if (CNT_W > PAY_W)   begin : g_bad_cnt $error("count wider than payload"); end
      if (TICK_DIV < 1)    begin : g_bad_div $error("TICK_DIV must be at least 1"); end
      if (ADDR_W < 6)      begin : g_bad_a   $error("address too narrow for offsets"); end
   endgenerate

   logic             wr_ctrl, wr_stat, wr_cnt;
   reg_sel_e         rd_sel;
   logic [PAY_W-1:0] ctrl_q, stat_q, payload;
   logic [1:0]       cfg_q;
   logic [CNT_W-1:0] cnt_q;
   logic             cnt_zero, armed, expire, tick, req_q;

   assign payload = bus_wdata[PAY_W-1:0];

   wdog_bus_gate #(.ADDR_W(ADDR_W)) u_gate (
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .key       (bus_wdata[DATA_W-1 -: KEY_W]),
      .wr_ctrl   (wr_ctrl),
      .wr_stat   (wr_stat),
      .wr_cnt    (wr_cnt),
      .rd_sel    (rd_sel)
   );

   generate
      if (TICK_DIV == 1) begin : g_direct_tick
         assign tick = tick_src;
      end else begin : g_div_tick
         wdog_tick_div #(.DIV(TICK_DIV)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (tick_src),
            .restart (wr_cnt),
            .tick    (tick)
         );
      end
   endgenerate

   assign cfg_q  = ctrl_q[CFG_LSB +: 2];
   assign armed  = (cfg_q == CFG_FULL);
   assign expire = armed && cnt_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (expire) begin
         ctrl_q[CFG_LSB +: 2] <= 2'd0;
      end else if (wr_ctrl) begin
         ctrl_q <= payload;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stat_q <= '0;
      else if (wr_stat) stat_q <= payload;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= expire;
   end

   wdog_down_cnt #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_cnt),
      .load_val (bus_wdata[CNT_W-1:0]),
      .dec      (tick && armed && !cnt_zero),
      .cnt      (cnt_q),
      .zero     (cnt_zero)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (rd_sel)
         SEL_CTRL:  bus_rdata[PAY_W-1:0] = ctrl_q;
         SEL_STAT:  bus_rdata[PAY_W-1:0] = stat_q;
         SEL_COUNT: bus_rdata[CNT_W-1:0] = cnt_q;
         default:   bus_rdata = '0;
      endcase
   end

   assign reset_req = req_q;
endmodule

// File: rtl/guarded_wdog_ctrl_chk.sv
module guarded_wdog_ctrl_chk
   import wdog_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 20,
   parameter int PAY_W  = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              reset_req,
   input logic [1:0]        cfg_q,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [PAY_W-1:0]  stat_q,
   input logic              wr_cnt,
   input logic              wr_stat
);
   p_req_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |=> !reset_req);

   p_req_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> (cfg_q == 2'd0 && cnt_q == '0));

   p_bad_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_wdata[DATA_W-1 -: KEY_W] != KEY_VALUE) |=> $stable(stat_q));

   p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q != CFG_FULL && !wr_cnt) |=> $stable(cnt_q));

   p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cnt |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CNT_W'(1)));

   p_key_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1 -: KEY_W] == '0);

   p_stat_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stat |=> $stable(stat_q));
endmodule

bind guarded_wdog_ctrl guarded_wdog_ctrl_chk #(
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W),
   .PAY_W  (PAY_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .reset_req (reset_req),
   .cfg_q     (cfg_q),
   .cnt_q     (cnt_q),
   .stat_q    (stat_q),
   .wr_cnt    (wr_cnt),
   .wr_stat   (wr_stat)
);

// File: tb/guarded_wdog_ctrl_test.sv
module guarded_wdog_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int DIV = 3;
   localparam logic [7:0] A_CTRL = 8'h1C, A_STAT = 8'h20, A_CNT = 8'h24;

   logic        clk = 1'b0, rst_n = 1'b0, tick_src = 1'b1;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [7:0]  bus_addr = 8'h0;
   logic [31:0] bus_wdata = 32'h0, bus_rdata;
   logic        reset_req;
   int n_run = 0, n_fail = 0;
   bit done = 0;

   guarded_wdog_ctrl #(.TICK_DIV(DIV)) uut (
      .clk(clk), .rst_n(rst_n), .tick_src(tick_src),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reset_req(reset_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a negedge; returns at the next negedge after the capturing edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = 32'h0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_valid = 1'b0;
   endtask

   // watch count and request from cycle m0 (relative to the count-load edge)
   task automatic watch(input string req, input int n, input int m0, input int req_m, input int last_m);
      logic [31:0] v;
      for (int m = m0; m <= last_m; m++) begin
         rd(A_CNT, v);
         check(req, v, 32'((n > m / DIV) ? n - m / DIV : 0));
         check(req, 32'(reset_req), 32'(m == req_m));
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] held;
      bit saw_req;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CTRL, v);  check("R1 ctrl", v, 32'h0);
      rd(A_STAT, v);  check("R1 stat", v, 32'h0);
      rd(A_CNT, v);   check("R1 count", v, 32'h0);
      check("R1 req", 32'(reset_req), 32'h0);

      // R3 readback, R9 halt pattern, R10 count width and unknown offset
      wr(A_STAT, 32'h5A000555);
      rd(A_STAT, v);  check("R9 halt pattern", v, 32'h00000555);
      wr(A_CTRL, 32'h5A123410);
      rd(A_CTRL, v);  check("R3 ctrl payload", v, 32'h00123410);
      wr(A_CNT, 32'h5AF00007);
      rd(A_CNT, v);   check("R10 count bits 19:0", v, 32'h00000007);
      rd(8'h28, v);   check("R10 unknown offset", v, 32'h0);

      // R2 unkeyed writes to every register
      wr(A_STAT, 32'h5B000FFF);
      wr(A_CTRL, 32'h00000020);
      wr(A_CNT,  32'hA5000003);
      rd(A_STAT, v);  check("R2 stat", v, 32'h00000555);
      rd(A_CTRL, v);  check("R2 ctrl", v, 32'h00123410);
      rd(A_CNT, v);   check("R2 count", v, 32'h00000007);

      // R4 non-arming configuration values freeze the count
      for (int c = 0; c < 4; c++) begin
         if (c == 2) continue;
         wr(A_CNT, 32'h5A000009);
         wr(A_CTRL, 32'h5A000000 | 32'(c << 4));
         saw_req = 0;
         repeat (15) begin
            if (reset_req) saw_req = 1;
            @(negedge clk);
         end
         rd(A_CNT, v);  check("R4 frozen count", v, 32'd9);
         check("R4 no request", 32'(saw_req), 32'h0);
      end

      // R5/R6 sweep of load values with exact expiry timing
      for (int n = 0; n <= 5; n++) begin
         wr(A_CTRL, 32'h5A000102);
         wr(A_CNT, 32'h5A000000 | 32'(n));
         wr(A_CTRL, 32'h5A000020);
         watch("R6 sweep", n, 1, ((DIV*n > 1) ? DIV*n : 1) + 1, DIV*n + 6);
         rd(A_CTRL, v);  check("R6 cfg cleared", v, 32'h0);
      end
      rd(A_STAT, v);  check("R9 stat after expiries", v, 32'h00000555);

      // R5 tick_src low holds the count
      tick_src = 1'b0;
      wr(A_CNT, 32'h5A000006);
      wr(A_CTRL, 32'h5A000020);
      repeat (20) @(negedge clk);
      rd(A_CNT, v);  check("R5 held without tick_src", v, 32'd6);
      tick_src = 1'b1;
      wr(A_CTRL, 32'h5A000102);

      // R7 keepalive reload
      wr(A_CNT, 32'h5A000004);
      wr(A_CTRL, 32'h5A000020);
      repeat (7) @(negedge clk);
      rd(A_CNT, v);  check("R7 partly down", v, 32'd2);
      wr(A_CNT, 32'h5A000004);
      watch("R7 reload", 4, 0, DIV*4 + 1, DIV*4 + 4);

      // R8 stop
      wr(A_CNT, 32'h5A000005);
      wr(A_CTRL, 32'h5A000020);
      repeat (4) @(negedge clk);
      wr(A_CTRL, 32'h5A000102);
      rd(A_CNT, held);
      saw_req = 0;
      repeat (30) begin
         if (reset_req) saw_req = 1;
         @(negedge clk);
      end
      rd(A_CNT, v);   check("R8 count frozen", v, held);
      check("R8 no request", 32'(saw_req), 32'h0);
      rd(A_CTRL, v);  check("R8 ctrl readback", v, 32'h00000102);
      rd(A_STAT, v);  check("R9 stat final", v, 32'h00000555);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule